// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This sequential unit turns the operand fields of an already decoded instruction into an effective address and, where the mode calls for it, the operand value. Each request carries a 12-bit address field, a register selector, a 4-bit mode code and the address of the next instruction. A one-cycle start pulse begins a request while the unit is idle. When the request finishes, the unit raises a one-cycle done pulse and presents the effective address, the operand and an error flag in that same cycle.

The unit reads the general registers through a combinational read port. That port is sampled in the start cycle. Memory is reached through one read port with a request/valid handshake. Modes that follow pointers make several memory references in sequence. A small state machine steps through them: fetch a pointer, possibly fetch more pointers, then fetch the operand. The auto-indexing mode writes the incremented index register back through a write port in the done cycle.

Mode codes: 0 immediate, 1 direct, 2 indirect, 3 cascaded indirect, 4 register, 5 register-indirect, 6 displacement, 7 PC-relative, 8 base, 9 auto-indexed, 10 pre-indexed, 11 post-indexed, 12 stack top. Codes 13 to 15 are invalid. The word and address width is 16 bits and there are 8 registers. Register 7 is the stack pointer.

Top module: `eaddr_unit`

## Requirements
- R1: Mode 0 returns the 12-bit field sign-extended from bit 11 as the operand and 0 as the address. It makes no memory reference, and done rises one cycle after the start cycle.
- R2: Mode 1 takes the zero-extended field as the address and makes one reference to read the operand. Mode 4 returns the selected register as the operand, with address 0 and no memory reference.
- R3: Mode 2 reads the word at the zero-extended field, uses that word as the address, and reads the operand from it: two references in total.
- R4: Mode 3 reads a word at the field. If bit 15 of that word is set, the unit clears the bit and reads again at the result. When bit 15 is clear, the word becomes the address and the operand is read from it.
- R5: In mode 3, if 8 consecutive pointer words all have bit 15 set, done rises with err set after the 8th read. The address is then the 8th word with bit 15 cleared, the operand is 0, and no operand read is made. A chain of 7 such words followed by a clear word finishes normally without error.
- R6: Mode 5 uses the selected register as the address. Mode 12 uses register 7 whatever the selector holds. Each makes one reference.
- R7: Modes 6 and 8 form the address as the zero-extended field plus the selected register, modulo 2^16. Neither mode writes any register.
- R8: Mode 7 forms the address as the next-instruction address plus the field sign-extended from bit 11.
- R9: Mode 9 forms the address as the zero-extended field plus the selected register. In the done cycle it writes that register's old value plus one back to the same register.
- R10: Mode 10 reads a pointer at field plus register and reads the operand at that pointer. Mode 11 reads a pointer at the field and reads the operand at pointer plus register.
- R11: mem_req stays high with a stable mem_addr until mem_valid is seen. Done rises in the cycle after the valid of the last reference.
- R12: A start pulse while busy is ignored, and the running request completes with its own inputs.
- R13: Codes 13 to 15 give done with err set one cycle after start, with address 0, operand 0 and no memory reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a request (used only while idle) |
| mode_i | input | 4 | Addressing mode code |
| field_i | input | 12 | Instruction address field |
| rsel_i | input | 3 | Register selector |
| pc_i | input | 16 | Next-instruction address |
| reg_raddr_o | output | 3 | Register read index |
| reg_rdata_i | input | 16 | Register read data (combinational) |
| reg_we_o | output | 1 | Register write enable (auto-index) |
| reg_waddr_o | output | 3 | Register write index |
| reg_wdata_o | output | 16 | Register write data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_valid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 16 | Memory read data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ea_o | output | 16 | Effective address, valid with done |
| operand_o | output | 16 | Operand value, valid with done |
| err_o | output | 1 | Error, valid with done |

## Verification
Most internal faults appear in the done cycle of the affected request. A wrong address register shows as a wrong ea_o and, through the operand read, a wrong operand_o. A wrong next-state choice changes the number of handshakes, so the latency differs from one cycle plus two per reference.

A miscounted cascade depth shows in the same request: either err_o rises on the legal 7-level chain, or it fails to rise on the 8-level chain. A bad write-back stays hidden until a later register-mode read returns the wrong value. That is why every auto-index request is followed at once by such a read.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;

    typedef logic [3:0] mode_t;

    localparam mode_t MODE_IMM   = 4'd0;
    localparam mode_t MODE_DIR   = 4'd1;
    localparam mode_t MODE_IND   = 4'd2;
    localparam mode_t MODE_CASC  = 4'd3;
    localparam mode_t MODE_REG   = 4'd4;
    localparam mode_t MODE_RIND  = 4'd5;
    localparam mode_t MODE_DISP  = 4'd6;
    localparam mode_t MODE_PCREL = 4'd7;
    localparam mode_t MODE_BASE  = 4'd8;
    localparam mode_t MODE_AUTO  = 4'd9;
    localparam mode_t MODE_PRE   = 4'd10;
    localparam mode_t MODE_POST  = 4'd11;
    localparam mode_t MODE_STACK = 4'd12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_OPND = 2'd2
    } state_e;

endpackage

// File: rtl/eaddr_calc.sv
module eaddr_calc
    import eaddr_pkg::*;
#(
    parameter int DW = 16,
    parameter int FW = 12
) (
    input  mode_t          mode_i,
    input  logic [FW-1:0]  field_i,
    input  logic [DW-1:0]  regval_i,
    input  logic [DW-1:0]  pc_i,
    output logic [DW-1:0]  first_addr_o,
    output logic [DW-1:0]  direct_val_o,
    output logic           needs_mem_o,
    output logic           first_ptr_o,
    output logic           invalid_o
);
    localparam int XW = DW - FW;

    logic [DW-1:0] fld_zx;
    logic [DW-1:0] fld_sx;

    assign fld_zx = {{XW{1'b0}}, field_i};
    assign fld_sx = {{XW{field_i[FW-1]}}, field_i};

    always_comb begin
        first_addr_o = '0;
        direct_val_o = '0;
        needs_mem_o  = 1'b1;
        first_ptr_o  = 1'b0;
        invalid_o    = 1'b0;
        case (mode_i)
            MODE_IMM: begin
                needs_mem_o  = 1'b0;
                direct_val_o = fld_sx;
            end
            MODE_REG: begin
                needs_mem_o  = 1'b0;
                direct_val_o = regval_i;
            end
            MODE_DIR:                      first_addr_o = fld_zx;
            MODE_IND, MODE_CASC, MODE_POST: begin
                first_addr_o = fld_zx;
                first_ptr_o  = 1'b1;
            end
            MODE_RIND, MODE_STACK:         first_addr_o = regval_i;
            MODE_DISP, MODE_BASE, MODE_AUTO: first_addr_o = fld_zx + regval_i;
            MODE_PCREL:                    first_addr_o = pc_i + fld_sx;
            MODE_PRE: begin
                first_addr_o = fld_zx + regval_i;
                first_ptr_o  = 1'b1;
            end
            default: begin
                needs_mem_o = 1'b0;
                invalid_o   = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (!needs_mem_o) begin
            assert_nomem_noptr_R1: assert (!first_ptr_o);
        end
    end

endmodule

// File: rtl/eaddr_seq.sv
module eaddr_seq
    import eaddr_pkg::*;
#(
    parameter int DW   = 16,
    parameter int RSW  = 3,
    parameter int MAXD = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  mode_t          mode_i,
    input  logic [RSW-1:0] rsel_i,
    input  logic [DW-1:0]  regval_i,
    input  logic [DW-1:0]  first_addr_i,
    input  logic [DW-1:0]  direct_val_i,
    input  logic           needs_mem_i,
    input  logic           first_ptr_i,
    input  logic           invalid_i,
    output logic           mem_req_o,
    output logic [DW-1:0]  mem_addr_o,
    input  logic           mem_valid_i,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [DW-1:0]  ea_o,
    output logic [DW-1:0]  operand_o,
    output logic           err_o,
    output logic           reg_we_o,
    output logic [RSW-1:0] reg_waddr_o,
    output logic [DW-1:0]  reg_wdata_o
);
    localparam int DEPW = $clog2(MAXD + 1);
    localparam logic [DW-1:0]   MSB_BIT  = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DEPW-1:0] LAST_LVL = DEPW'(MAXD - 1);

    typedef struct packed {
        state_e         state;
        mode_t          mode;
        logic [RSW-1:0] rsel;
        logic [DW-1:0]  regv;
        logic [DW-1:0]  addr;
        logic [DEPW-1:0] depth;
        logic [DW-1:0]  operand;
        logic           done;
        logic           err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.mode    = mode_i;
                    s_d.rsel    = rsel_i;
                    s_d.regv    = regval_i;
                    s_d.depth   = '0;
                    s_d.operand = '0;
                    s_d.addr    = '0;
                    if (invalid_i) begin
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                    end else if (!needs_mem_i) begin
                        s_d.done    = 1'b1;
                        s_d.operand = direct_val_i;
                    end else begin
                        s_d.addr  = first_addr_i;
                        s_d.state = first_ptr_i ? ST_PTR : ST_OPND;
                    end
                end
            end
            ST_PTR: begin
                if (mem_valid_i) begin
                    case (s_q.mode)
                        MODE_CASC: begin
                            if (mem_rdata_i[DW-1]) begin
                                s_d.addr = mem_rdata_i & ~MSB_BIT;
                                if (s_q.depth == LAST_LVL) begin
                                    s_d.done  = 1'b1;
                                    s_d.err   = 1'b1;
                                    s_d.state = ST_IDLE;
                                end else begin
                                    s_d.depth = s_q.depth + 1'b1;
                                end
                            end else begin
                                s_d.addr  = mem_rdata_i;
                                s_d.state = ST_OPND;
                            end
                        end
                        MODE_POST: begin
                            s_d.addr  = mem_rdata_i + s_q.regv;
                            s_d.state = ST_OPND;
                        end
                        default: begin
                            s_d.addr  = mem_rdata_i;
                            s_d.state = ST_OPND;
                        end
                    endcase
                end
            end
            ST_OPND: begin
                if (mem_valid_i) begin
                    s_d.operand = mem_rdata_i;
                    s_d.done    = 1'b1;
                    s_d.state   = ST_IDLE;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o      = (s_q.state != ST_IDLE);
    assign mem_req_o   = busy_o;
    assign mem_addr_o  = s_q.addr;
    assign ea_o        = s_q.addr;
    assign operand_o   = s_q.operand;
    assign done_o      = s_q.done;
    assign err_o       = s_q.err;
    assign reg_we_o    = s_q.done && !s_q.err && (s_q.mode == MODE_AUTO);
    assign reg_waddr_o = s_q.rsel;
    assign reg_wdata_o = s_q.regv + 1'b1;

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_wb_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> done_o);

    assert_err_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    assert_depth_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.depth < DEPW'(MAXD));

    assert_busy_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(s_q.mode) && $stable(s_q.rsel)));

    assert_imm_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && mode_i == MODE_IMM) |=> (done_o && !mem_req_o && !err_o));

    assert_invalid_err_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && invalid_i) |=> (done_o && err_o && !mem_req_o));

endmodule

// File: rtl/eaddr_unit.sv
module eaddr_unit
    import eaddr_pkg::*;
#(
    parameter int DW     = 16,
    parameter int FW     = 12,
    parameter int NREG   = 8,
    parameter int SP_IDX = 7,
    parameter int MAXD   = 8,
    localparam int RSW   = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [3:0]     mode_i,
    input  logic [FW-1:0]  field_i,
    input  logic [RSW-1:0] rsel_i,
    input  logic [DW-1:0]  pc_i,
    output logic [RSW-1:0] reg_raddr_o,
    input  logic [DW-1:0]  reg_rdata_i,
    output logic           reg_we_o,
    output logic [RSW-1:0] reg_waddr_o,
    output logic [DW-1:0]  reg_wdata_o,
    output logic           mem_req_o,
    output logic [DW-1:0]  mem_addr_o,
    input  logic           mem_valid_i,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [DW-1:0]  ea_o,
    output logic [DW-1:0]  operand_o,
    output logic           err_o
);
    logic [DW-1:0] first_addr;
    logic [DW-1:0] direct_val;
    logic          needs_mem;
    logic          first_ptr;
    logic          invalid;

    assign reg_raddr_o = (mode_i == MODE_STACK) ? RSW'(SP_IDX) : rsel_i;

    eaddr_calc #(.DW(DW), .FW(FW)) u_calc (
        .mode_i       (mode_i),
        .field_i      (field_i),
        .regval_i     (reg_rdata_i),
        .pc_i         (pc_i),
        .first_addr_o (first_addr),
        .direct_val_o (direct_val),
        .needs_mem_o  (needs_mem),
        .first_ptr_o  (first_ptr),
        .invalid_o    (invalid)
    );

    eaddr_seq #(.DW(DW), .RSW(RSW), .MAXD(MAXD)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .rsel_i       (reg_raddr_o),
        .regval_i     (reg_rdata_i),
        .first_addr_i (first_addr),
        .direct_val_i (direct_val),
        .needs_mem_i  (needs_mem),
        .first_ptr_i  (first_ptr),
        .invalid_i    (invalid),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_valid_i  (mem_valid_i),
        .mem_rdata_i  (mem_rdata_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .ea_o         (ea_o),
        .operand_o    (operand_o),
        .err_o        (err_o),
        .reg_we_o     (reg_we_o),
        .reg_waddr_o  (reg_waddr_o),
        .reg_wdata_o  (reg_wdata_o)
    );

endmodule

// File: tb/eaddr_unit_bench.sv
module eaddr_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [11:0] field_i = '0;
    logic [2:0]  rsel_i = '0;
    logic [15:0] pc_i = 16'h0008;
    logic [2:0]  reg_raddr_o;
    logic [15:0] reg_rdata_i;
    logic        reg_we_o;
    logic [2:0]  reg_waddr_o;
    logic [15:0] reg_wdata_o;
    logic        mem_req_o;
    logic [15:0] mem_addr_o;
    logic        mem_valid_i;
    logic [15:0] mem_rdata_i;
    logic        busy_o, done_o, err_o;
    logic [15:0] ea_o, operand_o;

    int checks = 0;
    int fails = 0;
    int ref_count = 0;
    int done_count = 0;

    logic [15:0] memarr [64];
    logic [15:0] regs [8];

    always #2 clk = ~clk;

    eaddr_unit u_eaddr_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .field_i(field_i), .rsel_i(rsel_i), .pc_i(pc_i),
        .reg_raddr_o(reg_raddr_o), .reg_rdata_i(reg_rdata_i),
        .reg_we_o(reg_we_o), .reg_waddr_o(reg_waddr_o), .reg_wdata_o(reg_wdata_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .ea_o(ea_o),
        .operand_o(operand_o), .err_o(err_o)
    );

    assign reg_rdata_i = regs[reg_raddr_o];

    // Memory model: answers each request one cycle later; register file with reset contents.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_valid_i <= 1'b0;
            mem_rdata_i <= '0;
            for (int i = 0; i < 64; i++) memarr[i] <= 16'h5000 | 16'(i);
            memarr[4] <= 16'h0011;
            memarr[7] <= 16'h0022;
            memarr[9] <= 16'h800A;
            memarr[10] <= 16'h800B;
            memarr[11] <= 16'h0025;
            for (int k = 0; k < 8; k++) memarr[56 + k] <= 16'h8000 | 16'(57 + k);
            regs[0] <= 16'h0000; regs[1] <= 16'h0002; regs[2] <= 16'h0005;
            regs[3] <= 16'h0010; regs[4] <= 16'h0020; regs[5] <= 16'hFFFF;
            regs[6] <= 16'h000A; regs[7] <= 16'h0030;
        end else begin
            mem_valid_i <= mem_req_o && !mem_valid_i;
            mem_rdata_i <= memarr[mem_addr_o[5:0]];
            if (mem_req_o && mem_valid_i) ref_count <= ref_count + 1;
            if (done_o) done_count <= done_count + 1;
            if (reg_we_o) regs[reg_waddr_o] <= reg_wdata_o;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0]  mode;
        logic [11:0] field;
        logic [2:0]  rsel;
        logic [15:0] ea;
        logic [15:0] op;
        logic        err;
        logic [4:0]  refs;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  12'h7FF, 3'd0, 16'h0000, 16'h07FF, 1'b0, 5'd0, 4'd1},  // R1
        '{4'd0,  12'h800, 3'd0, 16'h0000, 16'hF800, 1'b0, 5'd0, 4'd1},  // R1
        '{4'd1,  12'h015, 3'd0, 16'h0015, 16'h5015, 1'b0, 5'd1, 4'd2},  // R2
        '{4'd4,  12'h000, 3'd3, 16'h0000, 16'h0010, 1'b0, 5'd0, 4'd2},  // R2
        '{4'd2,  12'h004, 3'd0, 16'h0011, 16'h5011, 1'b0, 5'd2, 4'd3},  // R3
        '{4'd3,  12'h004, 3'd0, 16'h0011, 16'h5011, 1'b0, 5'd2, 4'd4},  // R4
        '{4'd3,  12'h009, 3'd0, 16'h0025, 16'h5025, 1'b0, 5'd4, 4'd4},  // R4
        '{4'd3,  12'h039, 3'd0, 16'h5000, 16'h5000, 1'b0, 5'd9, 4'd5},  // R5
        '{4'd3,  12'h038, 3'd0, 16'h0040, 16'h0000, 1'b1, 5'd8, 4'd5},  // R5
        '{4'd5,  12'h000, 3'd4, 16'h0020, 16'h5020, 1'b0, 5'd1, 4'd6},  // R6
        '{4'd12, 12'h005, 3'd1, 16'h0030, 16'h5030, 1'b0, 5'd1, 4'd6},  // R6
        '{4'd6,  12'h003, 3'd3, 16'h0013, 16'h5013, 1'b0, 5'd1, 4'd7},  // R7
        '{4'd4,  12'h000, 3'd3, 16'h0000, 16'h0010, 1'b0, 5'd0, 4'd7},  // R7 no write-back
        '{4'd8,  12'hFFF, 3'd2, 16'h1004, 16'h0011, 1'b0, 5'd1, 4'd7},  // R7
        '{4'd6,  12'h002, 3'd5, 16'h0001, 16'h5001, 1'b0, 5'd1, 4'd7},  // R7 wrap
        '{4'd7,  12'hFFE, 3'd0, 16'h0006, 16'h5006, 1'b0, 5'd1, 4'd8},  // R8
        '{4'd7,  12'h010, 3'd0, 16'h0018, 16'h5018, 1'b0, 5'd1, 4'd8},  // R8
        '{4'd9,  12'h010, 3'd6, 16'h001A, 16'h501A, 1'b0, 5'd1, 4'd9},  // R9
        '{4'd4,  12'h000, 3'd6, 16'h0000, 16'h000B, 1'b0, 5'd0, 4'd9},  // R9 readback
        '{4'd9,  12'h010, 3'd6, 16'h001B, 16'h501B, 1'b0, 5'd1, 4'd9},  // R9
        '{4'd10, 12'h002, 3'd2, 16'h0022, 16'h5022, 1'b0, 5'd2, 4'd10}, // R10
        '{4'd11, 12'h004, 3'd1, 16'h0013, 16'h5013, 1'b0, 5'd2, 4'd10}, // R10
        '{4'd13, 12'h004, 3'd0, 16'h0000, 16'h0000, 1'b1, 5'd0, 4'd13}, // R13
        '{4'd15, 12'h000, 3'd0, 16'h0000, 16'h0000, 1'b1, 5'd0, 4'd13}  // R13
    };

    task automatic run_vec(input vec_t v);
        int snap;
        int lat;
        string tag;
        tag = $sformatf("R%0d vec mode %0d field %0h", v.req, v.mode, v.field);
        @(negedge clk);
        mode_i = v.mode; field_i = v.field; rsel_i = v.rsel; start_i = 1'b1;
        snap = ref_count;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(done_o == 1'b1, {tag, " done"}, 32'(done_o), 32'd1);
        check(ea_o == v.ea, {tag, " ea"}, 32'(ea_o), 32'(v.ea));
        check(operand_o == v.op, {tag, " operand"}, 32'(operand_o), 32'(v.op));
        check(err_o == v.err, {tag, " err"}, 32'(err_o), 32'(v.err));
        check((ref_count - snap) == int'(v.refs), {tag, " refs (R11)"}, 32'(ref_count - snap), 32'(v.refs));
        check(lat == 1 + 2 * int'(v.refs), {tag, " latency (R11)"}, 32'(lat), 32'(1 + 2 * int'(v.refs)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int dc0;
        int k;
        repeat (3) @(negedge clk);
        check(!done_o && !busy_o && !mem_req_o && !reg_we_o && !err_o, "R11 reset state",
              {27'd0, done_o, busy_o, mem_req_o, reg_we_o, err_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_o && !busy_o && !mem_req_o, "R11 idle after reset",
              {29'd0, done_o, busy_o, mem_req_o}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R12: a second start while busy is ignored
        @(negedge clk);
        mode_i = 4'd1; field_i = 12'h015; rsel_i = 3'd0; start_i = 1'b1;
        dc0 = done_count;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        mode_i = 4'd0; field_i = 12'h123; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 0;
        while (!done_o && k < 20) begin
            @(negedge clk);
            k++;
        end
        check(operand_o == 16'h5015, "R12 operand of first request", 32'(operand_o), 32'h5015);
        check(ea_o == 16'h0015, "R12 ea of first request", 32'(ea_o), 32'h0015);
        repeat (4) @(negedge clk);
        check((done_count - dc0) == 1, "R12 single done pulse", 32'(done_count - dc0), 32'd1);
        check(!busy_o, "R12 idle afterwards", 32'(busy_o), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule